// File: doc/BRIEF.md
# Sense Reference Trim Search Controller

This block finds a digital trim code for the sense reference of a resistive non-volatile memory array. After a start pulse, it sets each candidate code on the reference one at a time. For every candidate it exercises a programmable run of sample addresses through a simple request/acknowledge memory port. Each sample address is written with an all-ones word and read back, then written with an all-zeros word and read back. This checks both resistance states against the reference. Every bit that differs from the expected word adds to an error count for that candidate.

A candidate passes when its error count does not exceed a programmable limit. After the sweep, the block keeps the lowest and highest passing codes and picks the code halfway between them. The datapath uses only registers, adders and comparators.

Several local references (regions) are searched strictly one after another, and each region gets its own result. A region with no passing code is flagged and gets no fuse. A region with a result is sent to a fuse-programming handshake together with the next unused one-time slot. While a search is running, the ready output stays low, which holds back every later self-test, repair step or normal read. The search can be started again in the field, and new results then go to fresh slots.

Top module: `trim_search_ctrl`

## Requirements
- R1: `ready` is low from reset and goes low in the cycle after a `start` pulse. It rises only after the last region has been fully handled. While `ready` is high there is no memory or fuse request.
- R2: For every candidate code, each of the addresses `base_addr` .. `base_addr + n_samples - 1` is visited in turn with this sequence: write all-ones, read, write all-zeros, read. An `n_samples` of 0 acts as 1.
- R3: The error count of a candidate is the number of read bits that differ from the word just written, summed over all of its sample reads. A candidate passes when this count is less than or equal to `err_limit`.
- R4: Candidate codes sweep upward from 0 to the 6-bit maximum of 63. The chosen code is (lowest passing + highest passing) >> 1.
- R5: If no candidate passes for a region, that region's bit in `region_fail` is set and no fuse request is made for it.
- R6: Regions are searched in index order 0 .. REGIONS-1, each with a fresh error count and a fresh pass window. `trim_region` names the region under test, and `trim_code` holds steady during every memory request.
- R7: A fuse request holds `fuse_region`, `fuse_slot` and `fuse_code` steady until `fuse_ack` arrives. No memory request is issued while it is pending.
- R8: Fuse slots are handed out in increasing order starting at 0. The count persists across restarts and is cleared only by reset.
- R9: When a region has a result but every slot (SLOTS of them) is used, `slot_overflow` is set and no fuse request is raised.
- R10: A memory request holds its address, direction and write data until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that begins a search of all regions |
| n_samples | input | ADDR_W | Number of sample addresses per candidate (0 acts as 1) |
| base_addr | input | ADDR_W | First sample address |
| err_limit | input | CNT_W | Largest error count that still passes |
| ready | output | 1 | High once a search has finished; gates the rest of self-test |
| trim_code | output | CODE_W | Candidate code driven to the reference |
| trim_region | output | REG_W | Region whose reference is being searched |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data (all ones or all zeros) |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | DATA_W | Read data |
| fuse_req | output | 1 | Fuse programming request |
| fuse_region | output | REG_W | Region of the result being stored |
| fuse_slot | output | SLOT_W | Spare slot to program |
| fuse_code | output | CODE_W | Chosen code to store |
| fuse_ack | input | 1 | Fuse programming complete |
| region_fail | output | REGIONS | Per-region flag: no passing code was found |
| slot_overflow | output | 1 | A result was found but no spare slot was left |

## Verification
The bench's memory model returns clean data inside a per-region window of codes. It returns one bad bit per read at the two codes next to that window and a fully inverted word elsewhere. Changing the error limit moves the window edges, so a wrong comparison (strictly less instead of less-or-equal) or a wrong error sum shifts the chosen midpoint. One region has no clean code at all, which catches a design that programs a fuse anyway. Another run has windows that touch codes 0 and 63, which exposes a sweep that stops early or wraps. The runs are chained until the slots run out, so a design that reuses a slot, fails to raise overflow, or resets its slot count on restart gets a wrong slot index in the fuse log. A reset in the middle of a search must bring the gate low and restart slot allocation at 0. The number of reads counted before the gate rises shows whether the gate opened before the last region was done.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WR1, S_RD1, S_WR0, S_RD0, S_EVAL, S_PICK, S_FUSE, S_NEXT, S_DONE
  } trim_state_e;
endpackage

// File: rtl/trim_err_acc.sv
// Sums the bit differences between read data and the expected word; saturates.
module trim_err_acc #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] expect_d,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] diff;
  logic [CNT_W-1:0]  ones;
  logic [CNT_W:0]    sum;

  always_comb begin
    diff = rdata ^ expect_d;
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(diff[i]);
    sum = {1'b0, count} + {1'b0, ones};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (add)    count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/trim_window.sv
// Keeps the lowest and highest passing codes and forms their midpoint.
module trim_window #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic              pass,
  input  logic [CODE_W-1:0] code,
  output logic              found,
  output logic [CODE_W-1:0] mid
);
  logic [CODE_W-1:0] lo_q, hi_q;
  logic [CODE_W:0]   span_sum;

  always_comb begin
    span_sum = {1'b0, lo_q} + {1'b0, hi_q};
    mid      = span_sum[CODE_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      found <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (upd && pass) begin
      if (!found) lo_q <= code;
      hi_q  <= code;
      found <= 1'b1;
    end
  end
endmodule

// File: rtl/trim_slot_alloc.sv
// Hands out one-time fuse slots in order; only reset returns them.
module trim_slot_alloc #(
  parameter int SLOTS  = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  output logic [SLOT_W-1:0] next_slot,
  output logic              none_left
);
  assign none_left = (next_slot == SLOT_W'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst)                     next_slot <= '0;
    else if (take && !none_left) next_slot <= next_slot + SLOT_W'(1);
  end
endmodule

// File: rtl/trim_search_ctrl.sv
module trim_search_ctrl
  import trim_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 12,
  parameter int REGIONS = 2,
  parameter int SLOTS   = 6,
  parameter int REG_W   = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  parameter int SLOT_W  = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  n_samples,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [CNT_W-1:0]   err_limit,
  output logic               ready,
  output logic [CODE_W-1:0]  trim_code,
  output logic [REG_W-1:0]   trim_region,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               fuse_req,
  output logic [REG_W-1:0]   fuse_region,
  output logic [SLOT_W-1:0]  fuse_slot,
  output logic [CODE_W-1:0]  fuse_code,
  input  logic               fuse_ack,
  output logic [REGIONS-1:0] region_fail,
  output logic               slot_overflow
);
  localparam logic [REG_W-1:0] LAST_REG = REG_W'(REGIONS - 1);

  trim_state_e       state;
  logic [ADDR_W-1:0] smp;
  logic [ADDR_W:0]   smp_next;
  logic              last_smp, acc_clr, acc_add, win_clr, win_upd, pass, take;
  logic              found, none_left;
  logic [CNT_W-1:0]  err_cnt;
  logic [CODE_W-1:0] mid;
  logic [SLOT_W-1:0] next_slot;
  logic [DATA_W-1:0] expect_d;

  // Decoded strobes of the sequencer
  always_comb begin
    smp_next  = {1'b0, smp} + 1'b1;
    last_smp  = smp_next >= {1'b0, n_samples};
    mem_req   = (state == S_WR1) || (state == S_RD1) ||
                (state == S_WR0) || (state == S_RD0);
    mem_we    = (state == S_WR1) || (state == S_WR0);
    mem_wdata = (state == S_WR1) ? '1 : '0;
    mem_addr  = base_addr + smp;
    expect_d  = (state == S_RD1) ? '1 : '0;
    acc_add   = mem_ack && ((state == S_RD1) || (state == S_RD0));
    acc_clr   = (state == S_EVAL) || (state == S_IDLE) ||
                (state == S_DONE) || (state == S_NEXT);
    win_clr   = (state == S_IDLE) || (state == S_DONE) || (state == S_NEXT);
    win_upd   = (state == S_EVAL);
    pass      = err_cnt <= err_limit;
    take      = (state == S_FUSE) && fuse_ack;
    fuse_region = trim_region;
  end

  trim_err_acc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
    .rdata(mem_rdata), .expect_d(expect_d), .count(err_cnt)
  );

  trim_window #(.CODE_W(CODE_W)) u_win (
    .clk(clk), .rst(rst), .clr(win_clr), .upd(win_upd), .pass(pass),
    .code(trim_code), .found(found), .mid(mid)
  );

  trim_slot_alloc #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .take(take),
    .next_slot(next_slot), .none_left(none_left)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      smp           <= '0;
      trim_code     <= '0;
      trim_region   <= '0;
      ready         <= 1'b0;
      fuse_req      <= 1'b0;
      fuse_slot     <= '0;
      fuse_code     <= '0;
      region_fail   <= '0;
      slot_overflow <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          ready         <= 1'b0;
          smp           <= '0;
          trim_code     <= '0;
          trim_region   <= '0;
          region_fail   <= '0;
          slot_overflow <= 1'b0;
          state         <= S_WR1;
        end
        S_WR1: if (mem_ack) state <= S_RD1;
        S_RD1: if (mem_ack) state <= S_WR0;
        S_WR0: if (mem_ack) state <= S_RD0;
        S_RD0: if (mem_ack) begin
          if (last_smp) state <= S_EVAL;
          else begin
            smp   <= smp + 1'b1;
            state <= S_WR1;
          end
        end
        S_EVAL: begin
          smp <= '0;
          if (trim_code == '1) state <= S_PICK;
          else begin
            trim_code <= trim_code + 1'b1;
            state     <= S_WR1;
          end
        end
        S_PICK: begin
          if (!found) begin
            region_fail[trim_region] <= 1'b1;
            state <= S_NEXT;
          end else if (none_left) begin
            slot_overflow <= 1'b1;
            state <= S_NEXT;
          end else begin
            fuse_req  <= 1'b1;
            fuse_code <= mid;
            fuse_slot <= next_slot;
            state     <= S_FUSE;
          end
        end
        S_FUSE: if (fuse_ack) begin
          fuse_req <= 1'b0;
          state    <= S_NEXT;
        end
        S_NEXT: begin
          if (trim_region == LAST_REG) begin
            ready <= 1'b1;
            state <= S_DONE;
          end else begin
            trim_region <= trim_region + REG_W'(1);
            trim_code   <= '0;
            state       <= S_WR1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_search_chk.sv
module trim_search_chk #(
  parameter int CODE_W = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 1,
  parameter int SLOTS  = 6,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic [CODE_W-1:0] trim_code,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              fuse_req,
  input logic [REG_W-1:0]  fuse_region,
  input logic [SLOT_W-1:0] fuse_slot,
  input logic [CODE_W-1:0] fuse_code,
  input logic              fuse_ack,
  input logic              slot_overflow
);
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!mem_req && !fuse_req));

  a_r2_write_pattern: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata == '1) || (mem_wdata == '0)));

  a_r6_code_steady: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> $stable(trim_code));

  a_r7_fuse_hold: assert property (@(posedge clk) disable iff (rst)
    (fuse_req && !fuse_ack) |=> (fuse_req && $stable(fuse_code) &&
                                 $stable(fuse_slot) && $stable(fuse_region)));

  a_r7_no_mem_in_fuse: assert property (@(posedge clk) disable iff (rst)
    fuse_req |-> !mem_req);

  a_r8_slot_range: assert property (@(posedge clk) disable iff (rst)
    fuse_req |-> (fuse_slot < SLOT_W'(SLOTS)));

  a_r9_overflow_no_req: assert property (@(posedge clk) disable iff (rst)
    slot_overflow |-> !fuse_req);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind trim_search_ctrl trim_search_chk #(
  .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REG_W(REG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .trim_code(trim_code),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .fuse_req(fuse_req),
  .fuse_region(fuse_region), .fuse_slot(fuse_slot), .fuse_code(fuse_code),
  .fuse_ack(fuse_ack), .slot_overflow(slot_overflow)
);

// File: tb/sim_trim_search_ctrl.sv
module sim_trim_search_ctrl;
  localparam int CODE_W = 6, DATA_W = 8, ADDR_W = 8, CNT_W = 12;
  localparam int REGIONS = 2, SLOTS = 6, REG_W = 1, SLOT_W = 3;
  localparam int NVEC = 4;
  // {lo0, hi0, lo1, hi1, limit, n_samples, base}
  localparam logic [47:0] VEC [NVEC] = '{
    {6'd10, 6'd30, 6'd40, 6'd50, 8'd0, 8'd2, 8'h10},
    {6'd0,  6'd5,  6'd60, 6'd63, 8'd4, 8'd2, 8'hF0},
    {6'd63, 6'd0,  6'd33, 6'd33, 8'd1, 8'd0, 8'h40},
    {6'd20, 6'd21, 6'd7,  6'd8,  8'd0, 8'd3, 8'h80}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [ADDR_W-1:0] n_samples = 0, base_addr = 0;
  logic [CNT_W-1:0] err_limit = 0;
  logic ready, mem_req, mem_we, mem_ack = 0, fuse_req, fuse_ack = 0, slot_overflow;
  logic [CODE_W-1:0] trim_code, fuse_code;
  logic [REG_W-1:0] trim_region, fuse_region;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata = 0;
  logic [SLOT_W-1:0] fuse_slot;
  logic [REGIONS-1:0] region_fail;

  always #10 clk = ~clk;

  trim_search_ctrl #(.CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .REGIONS(REGIONS), .SLOTS(SLOTS)) u0 (
    .clk(clk), .rst(rst), .start(start), .n_samples(n_samples),
    .base_addr(base_addr), .err_limit(err_limit), .ready(ready),
    .trim_code(trim_code), .trim_region(trim_region), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fuse_req(fuse_req),
    .fuse_region(fuse_region), .fuse_slot(fuse_slot), .fuse_code(fuse_code),
    .fuse_ack(fuse_ack), .region_fail(region_fail), .slot_overflow(slot_overflow));

  int checks = 0, failures = 0, cycles = 0;
  int lo_q [REGIONS], hi_q [REGIONS];
  int rd_cnt, seq_err, amin, amax, ph, nf, fdly, exp_slot;
  logic [DATA_W-1:0] last_w;
  logic [ADDR_W-1:0] last_a;
  int f_reg [4], f_slot [4], f_code [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference behaviour of the array: clean inside the window, one bad bit
  // at the neighbouring codes, fully inverted elsewhere.
  function automatic logic [DATA_W-1:0] err_mask(input int r, input int c);
    if (c >= lo_q[r] && c <= hi_q[r]) return '0;
    if (c + 1 == lo_q[r] || c == hi_q[r] + 1) return 8'h01;
    return '1;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (start) begin
      rd_cnt <= 0; seq_err <= 0; amin <= 255; amax <= 0; ph <= 0;
    end
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (int'(mem_addr) < amin) amin <= int'(mem_addr);
      if (int'(mem_addr) > amax) amax <= int'(mem_addr);
      ph <= (ph + 1) % 4;
      if (mem_we) begin
        last_w <= mem_wdata;
        last_a <= mem_addr;
        if (!((ph == 0 && mem_wdata == '1) || (ph == 2 && mem_wdata == '0)))
          seq_err <= seq_err + 1;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        mem_rdata <= last_w ^ err_mask(int'(trim_region), int'(trim_code));
        if (!(ph == 1 || ph == 3) || mem_addr != last_a) seq_err <= seq_err + 1;
      end
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (start) begin nf <= 0; fdly <= 0; end
    if (fuse_req && !fuse_ack) begin
      if (fdly == 2) begin
        fuse_ack <= 1'b1;
        fdly <= 0;
        if (nf < 4) begin
          f_reg[nf] <= int'(fuse_region);
          f_slot[nf] <= int'(fuse_slot);
          f_code[nf] <= int'(fuse_code);
        end
        nf <= nf + 1;
      end else fdly <= fdly + 1;
    end else fuse_ack <= 1'b0;
  end

  task automatic load_vec(input logic [47:0] v);
    lo_q[0] = int'(v[47:42]); hi_q[0] = int'(v[41:36]);
    lo_q[1] = int'(v[35:30]); hi_q[1] = int'(v[29:24]);
    err_limit = CNT_W'(v[23:16]);
    n_samples = v[15:8];
    base_addr = v[7:0];
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_ready();
    while (!ready && cycles < 150000) @(negedge clk);
  endtask

  task automatic run_and_check(input int vi);
    int neff, k, exp_ovf, ecnt, lo, hi, found;
    neff = (n_samples == 0) ? 1 : int'(n_samples);
    pulse_start();
    chk(ready == 0, $sformatf("R1 ready low after start v%0d", vi), ready, 0);
    wait_ready();
    @(negedge clk);
    chk(rd_cnt == REGIONS * 64 * 2 * neff, $sformatf("R1/R2 reads before ready v%0d", vi),
        rd_cnt, REGIONS * 64 * 2 * neff);
    chk(seq_err == 0, $sformatf("R2 write/read order v%0d", vi), seq_err, 0);
    chk(amin == int'(base_addr), $sformatf("R2 first address v%0d", vi), amin, int'(base_addr));
    chk(amax == int'(base_addr) + neff - 1, $sformatf("R2 last address v%0d", vi),
        amax, int'(base_addr) + neff - 1);
    k = 0; exp_ovf = 0;
    for (int r = 0; r < REGIONS; r++) begin
      found = 0; lo = 0; hi = 0;
      for (int c = 0; c < 64; c++) begin
        ecnt = 2 * neff * $countones(err_mask(r, c));
        if (ecnt <= int'(err_limit)) begin
          if (found == 0) lo = c;
          hi = c; found = 1;
        end
      end
      chk(region_fail[r] == (found == 0), $sformatf("R5 fail flag v%0d region %0d", vi, r),
          int'(region_fail[r]), found == 0);
      if (found != 0 && exp_slot < SLOTS) begin
        chk(f_reg[k] == r, $sformatf("R6 fuse region v%0d", vi), f_reg[k], r);
        chk(f_slot[k] == exp_slot, $sformatf("R8 fuse slot v%0d", vi), f_slot[k], exp_slot);
        chk(f_code[k] == (lo + hi) / 2, $sformatf("R3/R4 chosen code v%0d region %0d", vi, r),
            f_code[k], (lo + hi) / 2);
        k++; exp_slot++;
      end else if (found != 0) exp_ovf = 1;
    end
    chk(nf == k, $sformatf("R5/R9 fuse request count v%0d", vi), nf, k);
    chk(slot_overflow == exp_ovf, $sformatf("R9 overflow v%0d", vi), slot_overflow, exp_ovf);
  endtask

  initial begin
    exp_slot = 0;
    repeat (3) @(negedge clk);
    // Reset state
    chk(ready == 0, "R1 ready low in reset", ready, 0);
    chk(mem_req == 0 && fuse_req == 0, "R1 no requests in reset", mem_req, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(ready == 0, "R1 ready low before first search", ready, 0);
    chk(slot_overflow == 0 && region_fail == 0, "R5/R9 flags clear after reset",
        int'(region_fail), 0);

    for (int v = 0; v < NVEC; v++) begin
      load_vec(VEC[v]);
      run_and_check(v);
    end

    // Reset in the middle of a search returns the gate low and the slot count to 0
    load_vec(VEC[0]);
    pulse_start();
    repeat (100) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk(ready == 0 && mem_req == 0, "R1 reset mid-search", ready, 0);
    chk(trim_code == 0, "R6 code cleared by reset", int'(trim_code), 0);
    rst = 0;
    exp_slot = 0;
    @(negedge clk);
    run_and_check(10);

    if (cycles >= 150000) chk(0, "watchdog expired", cycles, 150000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule